// File: doc/BRIEF.md
# Tagged Entry FIFO Packer/Unpacker

This block sits between a 32-bit register port and the 16-bit entry streams of a serial-bus sequencer. Every transmit entry is a tag plus a byte, so one 32-bit software word carries two entries. On the transmit side a written word is split into two queued entries, low half first. On the receive side the sequencer hands in one byte at a time, and a software read returns up to two of them packed into one word. Both queues are sized in entries, which is half of their raw depth in bytes.

Software programs a transfer count for each direction before starting. The block uses the transmit count to find the last word of an odd-length message, and it enqueues only that word's lower entry. It raises a done flag when the programmed number of entries has left or arrived. In block mode it raises a service request each time a chunk of entries has moved. A transmit word that does not fit is dropped and flags an error. The sticky flags are cleared by writing ones.

Top module: `tagpack_top`

## Requirements
- R1: A word written on `wordData` queues bits [15:0] as the first entry and bits [31:16] as the second. Entries come out on `entryData` in write order, one per cycle in which `entryValid` and `entryReady` are both high.
- R2: When the programmed transmit count minus the entries already accepted is exactly 1, a written word queues only its bits [15:0]. Its upper half is discarded.
- R3: `rdWord` shows the oldest received byte in [7:0] and the next one in [23:16]. All other bits are zero, and a missing byte reads as zero. A read with `wordRe` removes min(2, held) bytes. A read with nothing held changes nothing.
- R4: Status layout: bit 4 is transmit-not-empty and bit 5 is receive-not-empty. Bit 6 is transmit-full, meaning fewer than two free entries. Bits 1-3 and 7 read zero.
- R5: Each queue holds exactly raw depth / 2 entries (`OUT_RAW_DEPTH/2` and `IN_RAW_DEPTH/2`).
- R6: With `blockMode` high, bit 8 sets each time `BLOCK_ENTRIES` more entries have been consumed, and bit 9 sets each time that many more bytes have been accepted. With `blockMode` low, neither bit sets.
- R7: Bit 10 sets on the consume that brings consumed entries equal to the transmit count. Bit 11 sets on the accept that brings received bytes equal to the receive count. Loading a count clears that side's counters, chunk position and done bit.
- R8: A word that needs more entries than are free is dropped whole, and bit 0 (overflow) sets. A byte arriving while the receive queue is full is dropped, and bit 0 sets.
- R9: When `clrWe` is high, a one in bit 0, 8, 9, 10 or 11 of `clrData` clears that flag. A flag that sets in the same cycle stays set. Other `clrData` bits have no effect.
- R10: After reset both queues are empty and `status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blockMode | input | 1 | 1 = chunked service requests, 0 = whole-transfer mode |
| outCntWe | input | 1 | Load transmit entry count from `cntData` |
| inCntWe | input | 1 | Load receive byte count from `cntData` |
| cntData | input | COUNT_W | Count value to load |
| wordWe | input | 1 | Write one 32-bit word into the transmit queue |
| wordData | input | 32 | Two transmit entries |
| wordRe | input | 1 | Read (pop) the packed receive word |
| rdWord | output | 32 | Packed receive bytes |
| entryValid | output | 1 | Transmit entry available |
| entryData | output | 16 | Oldest transmit entry |
| entryReady | input | 1 | Sequencer consumes the entry |
| byteValid | input | 1 | Sequencer delivers a received byte |
| byteData | input | 8 | Received byte |
| clrWe | input | 1 | Write-one-to-clear strobe |
| clrData | input | 12 | Clear mask |
| status | output | 12 | Flag vector |

## Verification
The bench builds the block with raw depths of 8, so each queue holds four entries. It sets the chunk size to two entries and the count width to 9. With these values the transmit queue fills after two words, so a third word reaches the overflow drop. A short five-entry message reaches the odd-tail case with a single trailing word. Service requests come every second entry, so the chunk counter wraps several times within a single short transfer. A long mixed random phase also puts loads, clears, reads and pushes in the same cycles.

// File: rtl/tagpack_pkg.sv
package tagpack_pkg;
  localparam int STAT_W    = 12;
  localparam int ST_OVF    = 0;
  localparam int ST_ONE    = 4;
  localparam int ST_INE    = 5;
  localparam int ST_OFULL  = 6;
  localparam int ST_OSVC   = 8;
  localparam int ST_ISVC   = 9;
  localparam int ST_ODONE  = 10;
  localparam int ST_IDONE  = 11;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] outPushN;  // entries written into transmit queue (0..2)
    logic       outPop;    // one entry leaves transmit queue
    logic       inPush;    // one byte enters receive queue
    logic [1:0] inPopN;    // bytes leaving receive queue (0..2)
  } tp_strobe_t;
endpackage

// File: rtl/tp_fifo.sv
module tp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       pushN,
  input  logic [WIDTH-1:0] pushData0,
  input  logic [WIDTH-1:0] pushData1,
  input  logic [1:0]       popN,
  output logic [OW-1:0]    occ,
  output logic [WIDTH-1:0] head0,
  output logic [WIDTH-1:0] head1
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(pushN);
      rdPtr <= rdPtr + PW'(popN);
      occ   <= occ + OW'(pushN) - OW'(popN);
    end
  end

  always_ff @(posedge clk) begin
    if (pushN != 2'd0) mem[wrPtr] <= pushData0;
    if (pushN == 2'd2) mem[wrPtr + PW'(1)] <= pushData1;
  end

  assign head0 = mem[rdPtr];
  assign head1 = mem[rdPtr + PW'(1)];

  // R5
  room_chk: assert property (@(posedge clk) disable iff (!rstN)
    OW'(pushN) <= (OW'(DEPTH) - occ));
  // R5
  bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(DEPTH));
  // R3
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rstN)
    OW'(popN) <= occ);
endmodule

// File: rtl/tp_datapath.sv
module tp_datapath import tagpack_pkg::*; #(
  parameter int OUT_DEPTH = 8,
  parameter int IN_DEPTH  = 8,
  localparam int OOW = $clog2(OUT_DEPTH + 1),
  localparam int IOW = $clog2(IN_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  tp_strobe_t      strobe,
  input  logic [31:0]     wordData,
  input  logic [7:0]      byteData,
  output logic [OOW-1:0]  outOcc,
  output logic [IOW-1:0]  inOcc,
  output logic [15:0]     entryData,
  output logic [31:0]     rdWord
);
  logic [15:0] outHead1;
  logic [7:0]  inHead0, inHead1;
  logic        unusedHead;

  tp_fifo #(.WIDTH(16), .DEPTH(OUT_DEPTH)) u_outQ (
    .clk(clk), .rstN(rstN),
    .pushN(strobe.outPushN),
    .pushData0(wordData[15:0]), .pushData1(wordData[31:16]),
    .popN({1'b0, strobe.outPop}),
    .occ(outOcc), .head0(entryData), .head1(outHead1)
  );

  tp_fifo #(.WIDTH(8), .DEPTH(IN_DEPTH)) u_inQ (
    .clk(clk), .rstN(rstN),
    .pushN({1'b0, strobe.inPush}),
    .pushData0(byteData), .pushData1(8'h00),
    .popN(strobe.inPopN),
    .occ(inOcc), .head0(inHead0), .head1(inHead1)
  );

  assign unusedHead = ^outHead1;

  always_comb begin
    rdWord = '0;
    if (inOcc != '0)        rdWord[7:0]   = inHead0;
    if (inOcc >= IOW'(2))   rdWord[23:16] = inHead1;
  end
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl import tagpack_pkg::*; #(
  parameter int OUT_DEPTH = 8,
  parameter int IN_DEPTH  = 8,
  parameter int BLOCK     = 4,
  parameter int COUNT_W   = 9,
  localparam int OOW = $clog2(OUT_DEPTH + 1),
  localparam int IOW = $clog2(IN_DEPTH + 1),
  localparam int BW  = $clog2(BLOCK + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blockMode,
  input  logic               outCntWe,
  input  logic               inCntWe,
  input  logic [COUNT_W-1:0] cntData,
  input  logic               wordWe,
  input  logic               wordRe,
  input  logic               entryReady,
  input  logic               byteValid,
  input  logic               clrWe,
  input  logic [STAT_W-1:0]  clrData,
  input  logic [OOW-1:0]     outOcc,
  input  logic [IOW-1:0]     inOcc,
  output tp_strobe_t         strobe,
  output logic               entryValid,
  output logic [STAT_W-1:0]  status
);
  logic [COUNT_W-1:0] outCnt, outPushed, outPopped, outRemain;
  logic [COUNT_W-1:0] inCnt, inRecv;
  logic [BW-1:0]      outChunk, inChunk;
  logic [OOW-1:0]     outFree;
  logic [1:0]         outNeed;
  logic               outFits;
  logic               ovf, oSvc, iSvc, oDone, iDone;
  logic               ovfSet, oSvcSet, iSvcSet, oDoneSet, iDoneSet;
  logic [STAT_W-1:0]  clrHit;
  logic               unusedClr;

  assign outFree   = OOW'(OUT_DEPTH) - outOcc;
  assign outRemain = outCnt - outPushed;
  assign outNeed   = (outRemain == COUNT_W'(1)) ? 2'd1 : 2'd2;
  assign outFits   = OOW'(outNeed) <= outFree;

  always_comb begin
    strobe.outPushN = (wordWe && outFits) ? outNeed : 2'd0;
    strobe.outPop   = entryReady && (outOcc != '0);
    strobe.inPush   = byteValid && (inOcc != IOW'(IN_DEPTH));
    if (!wordRe || inOcc == '0)  strobe.inPopN = 2'd0;
    else if (inOcc == IOW'(1))   strobe.inPopN = 2'd1;
    else                         strobe.inPopN = 2'd2;
  end

  assign entryValid = outOcc != '0;

  assign ovfSet   = (wordWe && !outFits) || (byteValid && inOcc == IOW'(IN_DEPTH));
  assign oDoneSet = strobe.outPop && !outCntWe && ((outPopped + COUNT_W'(1)) == outCnt);
  assign iDoneSet = strobe.inPush && !inCntWe && ((inRecv + COUNT_W'(1)) == inCnt);
  assign oSvcSet  = blockMode && strobe.outPop && !outCntWe && (outChunk == BW'(BLOCK - 1));
  assign iSvcSet  = blockMode && strobe.inPush && !inCntWe && (inChunk == BW'(BLOCK - 1));
  assign clrHit   = clrWe ? clrData : '0;
  assign unusedClr = ^{clrData[7:1]};

  // transmit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt <= '0; outPushed <= '0; outPopped <= '0; outChunk <= '0;
    end else if (outCntWe) begin
      outCnt <= cntData; outPushed <= '0; outPopped <= '0; outChunk <= '0;
    end else begin
      outPushed <= outPushed + COUNT_W'(strobe.outPushN);
      if (strobe.outPop) begin
        outPopped <= outPopped + COUNT_W'(1);
        outChunk  <= (outChunk == BW'(BLOCK - 1)) ? '0 : outChunk + BW'(1);
      end
    end
  end

  // receive counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt <= '0; inRecv <= '0; inChunk <= '0;
    end else if (inCntWe) begin
      inCnt <= cntData; inRecv <= '0; inChunk <= '0;
    end else if (strobe.inPush) begin
      inRecv  <= inRecv + COUNT_W'(1);
      inChunk <= (inChunk == BW'(BLOCK - 1)) ? '0 : inChunk + BW'(1);
    end
  end

  // sticky flags: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovf <= 1'b0; oSvc <= 1'b0; iSvc <= 1'b0; oDone <= 1'b0; iDone <= 1'b0;
    end else begin
      ovf   <= ovfSet  | (ovf  & ~clrHit[ST_OVF]);
      oSvc  <= oSvcSet | (oSvc & ~clrHit[ST_OSVC]);
      iSvc  <= iSvcSet | (iSvc & ~clrHit[ST_ISVC]);
      oDone <= outCntWe ? 1'b0 : (oDoneSet | (oDone & ~clrHit[ST_ODONE]));
      iDone <= inCntWe  ? 1'b0 : (iDoneSet | (iDone & ~clrHit[ST_IDONE]));
    end
  end

  always_comb begin
    status           = '0;
    status[ST_OVF]   = ovf;
    status[ST_ONE]   = outOcc != '0;
    status[ST_INE]   = inOcc != '0;
    status[ST_OFULL] = outFree < OOW'(2);
    status[ST_OSVC]  = oSvc;
    status[ST_ISVC]  = iSvc;
    status[ST_ODONE] = oDone;
    status[ST_IDONE] = iDone;
  end

  // R6
  svc_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oSvc) |-> $past(blockMode));
  // R7
  done_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oDone) |-> ($past(outOcc) != '0));
  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordWe && !outFits) |=> status[ST_OVF]);
  // R9
  clr_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrData[ST_OSVC] && !oSvcSet) |=> !status[ST_OSVC]);
  // R2
  tail_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordWe && outRemain == COUNT_W'(1) && outFits) |=> (outOcc == $past(outOcc) + OOW'(1) - OOW'($past(strobe.outPop))));
endmodule

// File: rtl/tagpack_top.sv
module tagpack_top import tagpack_pkg::*; #(
  parameter int OUT_RAW_DEPTH = 16,
  parameter int IN_RAW_DEPTH  = 16,
  parameter int BLOCK_ENTRIES = 4,
  parameter int COUNT_W       = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               blockMode,
  input  logic               outCntWe,
  input  logic               inCntWe,
  input  logic [COUNT_W-1:0] cntData,
  input  logic               wordWe,
  input  logic [31:0]        wordData,
  input  logic               wordRe,
  output logic [31:0]        rdWord,
  output logic               entryValid,
  output logic [15:0]        entryData,
  input  logic               entryReady,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               clrWe,
  input  logic [11:0]        clrData,
  output logic [11:0]        status
);
  localparam int OUT_DEPTH = OUT_RAW_DEPTH / 2;
  localparam int IN_DEPTH  = IN_RAW_DEPTH / 2;
  localparam int OOW = $clog2(OUT_DEPTH + 1);
  localparam int IOW = $clog2(IN_DEPTH + 1);

  tp_strobe_t     strobe;
  logic [OOW-1:0] outOcc;
  logic [IOW-1:0] inOcc;

  tp_ctrl #(.OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH),
            .BLOCK(BLOCK_ENTRIES), .COUNT_W(COUNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .blockMode(blockMode),
    .outCntWe(outCntWe), .inCntWe(inCntWe), .cntData(cntData),
    .wordWe(wordWe), .wordRe(wordRe), .entryReady(entryReady),
    .byteValid(byteValid), .clrWe(clrWe), .clrData(clrData),
    .outOcc(outOcc), .inOcc(inOcc),
    .strobe(strobe), .entryValid(entryValid), .status(status)
  );

  tp_datapath #(.OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wordData(wordData), .byteData(byteData),
    .outOcc(outOcc), .inOcc(inOcc),
    .entryData(entryData), .rdWord(rdWord)
  );
endmodule

// File: tb/tagpack_top_tb.sv
`timescale 1ns/1ps
module tagpack_top_tb;
  localparam int OUT_RAW = 8;
  localparam int IN_RAW  = 8;
  localparam int BLK     = 2;
  localparam int CW      = 9;
  localparam int OD      = OUT_RAW / 2;
  localparam int ID      = IN_RAW / 2;
  localparam int CMASK   = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, blockMode, outCntWe, inCntWe, wordWe, wordRe, entryReady;
  logic byteValid, clrWe, entryValid;
  logic [CW-1:0] cntData;
  logic [31:0] wordData, rdWord;
  logic [15:0] entryData;
  logic [7:0]  byteData;
  logic [11:0] clrData, status;

  tagpack_top #(.OUT_RAW_DEPTH(OUT_RAW), .IN_RAW_DEPTH(IN_RAW),
                .BLOCK_ENTRIES(BLK), .COUNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .blockMode(blockMode),
    .outCntWe(outCntWe), .inCntWe(inCntWe), .cntData(cntData),
    .wordWe(wordWe), .wordData(wordData), .wordRe(wordRe), .rdWord(rdWord),
    .entryValid(entryValid), .entryData(entryData), .entryReady(entryReady),
    .byteValid(byteValid), .byteData(byteData),
    .clrWe(clrWe), .clrData(clrData), .status(status)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [15:0] outQ[$];
  logic [7:0]  inQ[$];
  int mOutCnt = 0, mOutPushed = 0, mOutPopped = 0, mOutChunk = 0;
  int mInCnt = 0, mInRecv = 0, mInChunk = 0;
  bit mOvf = 0, mOsvc = 0, mIsvc = 0, mOdone = 0, mIdone = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] expWord;
    logic [11:0] expStat;
    check(entryValid == (outQ.size() > 0), "R2 entry presence", {31'd0, entryValid}, {31'd0, outQ.size() > 0});
    if (outQ.size() > 0)
      check(entryData == outQ[0], "R1 entry order", {16'd0, entryData}, {16'd0, outQ[0]});
    expWord = '0;
    if (inQ.size() >= 1) expWord[7:0]   = inQ[0];
    if (inQ.size() >= 2) expWord[23:16] = inQ[1];
    check(rdWord === expWord, "R3 packed read", rdWord, expWord);
    expStat = '0;
    expStat[0]  = mOvf;
    expStat[4]  = outQ.size() > 0;
    expStat[5]  = inQ.size() > 0;
    expStat[6]  = (OD - outQ.size()) < 2;
    expStat[8]  = mOsvc;
    expStat[9]  = mIsvc;
    expStat[10] = mOdone;
    expStat[11] = mIdone;
    check(status[7:1] == expStat[7:1], "R4 level flags", {20'd0, status}, {20'd0, expStat});
    check(status[0] == expStat[0], "R8 overflow flag", {20'd0, status}, {20'd0, expStat});
    check(status[9:8] == expStat[9:8], "R6 service flags", {20'd0, status}, {20'd0, expStat});
    check(status[11:10] == expStat[11:10], "R7 done flags", {20'd0, status}, {20'd0, expStat});
  endtask

  task automatic modelStep();
    int oSize = outQ.size();
    int iSize = inQ.size();
    bit pop = entryReady && oSize > 0;
    int need = (((mOutCnt - mOutPushed) & CMASK) == 1) ? 1 : 2;
    bit fit = need <= (OD - oSize);
    bit iPush = byteValid && iSize < ID;
    int iPop = wordRe ? ((iSize >= 2) ? 2 : iSize) : 0;
    bit oDoneSet = pop && !outCntWe && (((mOutPopped + 1) & CMASK) == mOutCnt);
    bit iDoneSet = iPush && !inCntWe && (((mInRecv + 1) & CMASK) == mInCnt);
    bit oSvcSet = blockMode && pop && !outCntWe && (mOutChunk == BLK - 1);
    bit iSvcSet = blockMode && iPush && !inCntWe && (mInChunk == BLK - 1);
    bit ovfSet = (wordWe && !fit) || (byteValid && iSize == ID);
    logic [11:0] cm = clrWe ? clrData : 12'd0;
    if (pop) void'(outQ.pop_front());
    if (wordWe && fit) begin
      outQ.push_back(wordData[15:0]);
      if (need == 2) outQ.push_back(wordData[31:16]);
    end
    for (int k = 0; k < iPop; k++) void'(inQ.pop_front());
    if (iPush) inQ.push_back(byteData);
    if (outCntWe) begin
      mOutCnt = int'(cntData); mOutPushed = 0; mOutPopped = 0; mOutChunk = 0;
    end else begin
      if (wordWe && fit) mOutPushed = (mOutPushed + need) & CMASK;
      if (pop) begin
        mOutPopped = (mOutPopped + 1) & CMASK;
        mOutChunk = (mOutChunk == BLK - 1) ? 0 : mOutChunk + 1;
      end
    end
    if (inCntWe) begin
      mInCnt = int'(cntData); mInRecv = 0; mInChunk = 0;
    end else if (iPush) begin
      mInRecv = (mInRecv + 1) & CMASK;
      mInChunk = (mInChunk == BLK - 1) ? 0 : mInChunk + 1;
    end
    mOvf  = ovfSet  | (mOvf  & !cm[0]);
    mOsvc = oSvcSet | (mOsvc & !cm[8]);
    mIsvc = iSvcSet | (mIsvc & !cm[9]);
    mOdone = outCntWe ? 1'b0 : (oDoneSet | (mOdone & !cm[10]));
    mIdone = inCntWe  ? 1'b0 : (iDoneSet | (mIdone & !cm[11]));
  endtask

  task automatic cyc();
    compareAll();
    modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wordWe = 1'b1; wordData = d; cyc(); wordWe = 1'b0;
  endtask
  task automatic loadOut(input int n);
    outCntWe = 1'b1; cntData = CW'(n); cyc(); outCntWe = 1'b0;
  endtask
  task automatic loadIn(input int n);
    inCntWe = 1'b1; cntData = CW'(n); cyc(); inCntWe = 1'b0;
  endtask
  task automatic drain(input int n);
    entryReady = 1'b1; repeat (n) cyc(); entryReady = 1'b0;
  endtask
  task automatic pushByte(input logic [7:0] b);
    byteValid = 1'b1; byteData = b; cyc(); byteValid = 1'b0;
  endtask
  task automatic rd();
    wordRe = 1'b1; cyc(); wordRe = 1'b0;
  endtask
  task automatic clr(input logic [11:0] m);
    clrWe = 1'b1; clrData = m; cyc(); clrWe = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; blockMode = 1'b0; outCntWe = 1'b0; inCntWe = 1'b0; cntData = '0;
    wordWe = 1'b0; wordData = '0; wordRe = 1'b0; entryReady = 1'b0;
    byteValid = 1'b0; byteData = '0; clrWe = 1'b0; clrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check(status == 12'd0, "R10 reset status", {20'd0, status}, 32'd0);
    check(entryValid == 1'b0, "R10 reset empty", {31'd0, entryValid}, 32'd0);
    check(rdWord == 32'd0, "R10 reset read", rdWord, 32'd0);

    // whole-transfer mode, odd message of 5 entries
    loadOut(5);
    wr(32'h2222_1111);
    wr(32'h4444_3333);
    check(status[6] == 1'b1, "R5 full at half raw depth", {31'd0, status[6]}, 32'd1);
    wr(32'h6666_5555);
    check(status[0] == 1'b1, "R8 dropped word", {31'd0, status[0]}, 32'd1);
    check(entryData == 16'h1111, "R1 first entry low half", {16'd0, entryData}, 32'h1111);
    drain(4);
    check(status[10] == 1'b0, "R7 not done at 4 of 5", {31'd0, status[10]}, 32'd0);
    wr(32'h6666_5555);
    check(entryValid && entryData == 16'h5555, "R2 tail lower entry", {16'd0, entryData}, 32'h5555);
    drain(1);
    check(entryValid == 1'b0, "R2 upper half discarded", {31'd0, entryValid}, 32'd0);
    check(status[10] == 1'b1, "R7 transmit done", {31'd0, status[10]}, 32'd1);
    check(status[8] == 1'b0, "R6 no service in whole-transfer mode", {31'd0, status[8]}, 32'd0);
    pushByte(8'h5A);
    clr(12'hFFF);
    check(status[0] == 1'b0 && status[10] == 1'b0, "R9 clear sticky bits", {20'd0, status}, 32'h20);
    check(status[5] == 1'b1, "R9 level bit unaffected", {31'd0, status[5]}, 32'd1);
    rd();

    // chunked mode on transmit side
    blockMode = 1'b1;
    loadOut(4);
    wr(32'hBBBB_AAAA);
    wr(32'hDDDD_CCCC);
    drain(1);
    check(status[8] == 1'b0, "R6 no service after one entry", {31'd0, status[8]}, 32'd0);
    drain(1);
    check(status[8] == 1'b1, "R6 service after chunk", {31'd0, status[8]}, 32'd1);
    clr(12'h100);
    check(status[8] == 1'b0, "R9 service cleared", {31'd0, status[8]}, 32'd0);
    drain(1);
    entryReady = 1'b1; clrWe = 1'b1; clrData = 12'h500; cyc();
    entryReady = 1'b0; clrWe = 1'b0;
    check(status[8] == 1'b1, "R9 set wins over clear", {31'd0, status[8]}, 32'd1);
    check(status[10] == 1'b1, "R7 done at count 4", {31'd0, status[10]}, 32'd1);

    // receive side, whole-transfer mode
    blockMode = 1'b0;
    loadIn(3);
    pushByte(8'hA1);
    pushByte(8'hB2);
    check(rdWord == 32'h00B2_00A1, "R3 two bytes packed", rdWord, 32'h00B2_00A1);
    pushByte(8'hC3);
    check(status[11] == 1'b1, "R7 receive done", {31'd0, status[11]}, 32'd1);
    rd();
    check(rdWord == 32'h0000_00C3, "R3 single byte left", rdWord, 32'h0000_00C3);
    rd();
    check(rdWord == 32'd0 && status[5] == 1'b0, "R3 drained", rdWord, 32'd0);
    rd();
    check(status[5] == 1'b0 && rdWord == 32'd0, "R3 empty read no effect", rdWord, 32'd0);

    // receive side, chunked mode and overflow
    blockMode = 1'b1;
    loadIn(8);
    clr(12'hFFF);
    pushByte(8'h01); pushByte(8'h02);
    check(status[9] == 1'b1, "R6 receive service", {31'd0, status[9]}, 32'd1);
    pushByte(8'h03); pushByte(8'h04);
    pushByte(8'h05);
    check(status[0] == 1'b1, "R8 byte dropped when full", {31'd0, status[0]}, 32'd1);
    check(rdWord == 32'h0002_0001, "R5 receive holds four", rdWord, 32'h0002_0001);
    rd(); rd();

    // mixed traffic
    void'($urandom(32'd7));
    for (int i = 0; i < 4000; i++) begin
      wordWe     = ($urandom % 3) == 0;
      wordData   = $urandom;
      entryReady = ($urandom % 2) == 0;
      byteValid  = ($urandom % 3) == 0;
      byteData   = 8'($urandom);
      wordRe     = ($urandom % 4) == 0;
      clrWe      = ($urandom % 8) == 0;
      clrData    = 12'($urandom);
      outCntWe   = ($urandom % 40) == 0;
      inCntWe    = ($urandom % 40) == 0;
      cntData    = CW'($urandom % 16);
      if (($urandom % 50) == 0) blockMode = ~blockMode;
      cyc();
    end
    wordWe = 0; entryReady = 0; byteValid = 0; wordRe = 0; clrWe = 0;
    outCntWe = 0; inCntWe = 0;
    cyc();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule